// File: doc/BRIEF.md
# Mains-Synchronized Calendar Timekeeper

This block keeps the time of day and the calendar date. Its primary timebase is a clean single-cycle pulse that is derived from the AC mains, running at 50 Hz or 60 Hz as chosen by an input pin. When mains pulses stop arriving, the block declares the mains absent and keeps time from a crystal-derived tick. It returns to the mains on the next mains pulse. Moving from one source to the other leaves the hundredths count untouched, so no second is lost and none is counted twice.

The calendar holds hundredths, seconds, minutes, hours, day of month, month, a two-digit year and day of week. It corrects for leap years for the years 2000 to 2099. It can show hours in 12-hour form with a PM flag, and it can apply a daylight-saving step on two dates that software configures. A write port loads any field and a combinational read port returns it. All values are plain binary, not BCD, and hours are always written in 24-hour form.

Register map (4-bit address): 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day of month, 5 month, 6 year, 7 day of week, 8 control (bit 0 selects 12-hour display, bit 1 enables daylight saving), 9 DST start month, 10 DST start day, 11 DST end month, 12 DST end day. Addresses 13 to 15 read as zero.

Top module: `mains_calendar_keeper`

## Requirements
- R1: After reset, the time reads 00:00:00.00. The date reads day 1, month 1, year 0, with day of week 0. The control and DST registers read 0 and `mains_ok` is low.
- R2: With `sel_60hz` low, each mains tick adds exactly 2 hundredths.
- R3: With `sel_60hz` high, mains ticks add 1, 2, 2 hundredths in a repeating pattern, starting from a cleared fraction. This comes from a fractional accumulator with remainder modulo 60.
- R4: When hundredths pass 99, the time carries into seconds, then minutes, then hours. Hour 23 rolls into the next day. Day of week counts 0 to 6 and wraps to 0.
- R5: Months 4, 6, 9 and 11 have 30 days, and every other month has 31, except February. February has 29 days when the year is a multiple of 4 and 28 days otherwise. After the last day, the date moves to day 1 of the next month.
- R6: Day 31 of month 12 rolls over into day 1 of month 1. The year goes from 99 to 0.
- R7: `mains_ok` goes high on a mains tick. It goes low after LOSS_LIMIT crystal ticks in a row with no mains tick between them. While it is low, the crystal ticks add 100 to an accumulator, and each time the accumulator reaches XTAL_HZ it gives one hundredth.
- R8: While `mains_ok` is high, crystal ticks do not change the time.
- R9: With control bit 0 set, register 3 reads the hour as 12, 1 through 11, with bit 5 set for PM. Midnight reads as 12 with bit 5 clear, and noon reads as 12 with bit 5 set. With control bit 0 clear, register 3 reads the hour in 24-hour form.
- R10: With control bit 1 set, on the start month and day, a carry from 01:59:59.99 lands on 03:00:00.00.
- R11: With control bit 1 set, on the end month and day, the first carry out of hour 1 lands on 01:00 again. The second carry out of hour 1 that day goes on to 02:00.
- R12: A write to any of registers 1 to 7 clears the hundredths and the fractional accumulators. A write to register 0 loads the hundredths. A tick that arrives in the same cycle as such a write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_tick | input | 1 | Single-cycle mains pulse |
| xtal_tick | input | 1 | Single-cycle crystal-derived pulse |
| sel_60hz | input | 1 | 1: the mains runs at 60 Hz, 0: 50 Hz |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data for rd_addr |
| mains_ok | output | 1 | Mains pulses are present |

## Verification
The bench builds the block with XTAL_HZ = 200 and LOSS_LIMIT = 5. With these values, one hundredth arrives every two crystal ticks, and the mains is declared lost after five crystal ticks. The switchover, the return to the mains and the accumulator behaviour therefore happen within a few dozen cycles rather than thousands. All calendar boundaries are reached by loading the time near the boundary and then giving one mains tick. This covers leap and non-leap February, 30-day months, the end of the year and both daylight-saving dates.

// File: rtl/mct_pkg.sv
package mct_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  typedef enum logic [3:0] {
    RA_HUND  = 4'd0,
    RA_SEC   = 4'd1,
    RA_MIN   = 4'd2,
    RA_HOUR  = 4'd3,
    RA_DAY   = 4'd4,
    RA_MON   = 4'd5,
    RA_YEAR  = 4'd6,
    RA_WDAY  = 4'd7,
    RA_CTRL  = 4'd8,
    RA_DS_SM = 4'd9,
    RA_DS_SD = 4'd10,
    RA_DS_EM = 4'd11,
    RA_DS_ED = 4'd12
  } reg_addr_e;

  // Two-digit year, 2000..2099: every multiple of four is a leap year.
  function automatic logic is_leap(input logic [6:0] yr);
    return (yr[1:0] == 2'b00);
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] mo, input logic [6:0] yr);
    case (mo)
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      4'd2:                    return is_leap(yr) ? 5'd29 : 5'd28;
      default:                 return 5'd31;
    endcase
  endfunction

  // Display form of the hour: bit 5 carries PM in 12-hour mode.
  function automatic logic [5:0] disp_hour(input logic [4:0] h24, input logic mode12);
    logic [4:0] h;
    if (!mode12) return {1'b0, h24};
    h = (h24 >= 5'd12) ? h24 - 5'd12 : h24;
    if (h == 5'd0) h = 5'd12;
    return {(h24 >= 5'd12), h};
  endfunction
endpackage

// File: rtl/mct_timebase.sv
module mct_timebase #(
  parameter int XTAL_HZ    = 32768,
  parameter int LOSS_LIMIT = 819
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_tick,
  input  logic       xtal_tick,
  input  logic       sel_60hz,
  input  logic       clear_frac,
  output logic [1:0] step,
  output logic       mains_ok
);
  localparam int XACC_W = $clog2(XTAL_HZ + 100) + 1;
  localparam int LOSS_W = $clog2(LOSS_LIMIT + 1);

  logic [6:0]        line_acc, line_rem;
  logic [7:0]        line_sum;
  logic [1:0]        line_step;
  logic [XACC_W-1:0] xtal_acc, xtal_sum;
  logic              xtal_step, use_xtal, loss_hit;
  logic [LOSS_W-1:0] loss_cnt;

  // Mains accumulator: 50 Hz is a plain 2, 60 Hz carries remainder mod 60.
  always_comb begin
    line_sum = {1'b0, line_acc} + 8'd100;
    if (!sel_60hz) begin
      line_step = 2'd2;
      line_rem  = line_acc;
    end else if (line_sum >= 8'd120) begin
      line_step = 2'd2;
      line_rem  = 7'(line_sum - 8'd120);
    end else begin
      line_step = 2'd1;
      line_rem  = 7'(line_sum - 8'd60);
    end
  end

  assign use_xtal  = xtal_tick && !line_tick && !mains_ok;
  assign xtal_sum  = xtal_acc + XACC_W'(100);
  assign xtal_step = (xtal_sum >= XACC_W'(XTAL_HZ));
  assign loss_hit  = xtal_tick && !line_tick && mains_ok &&
                     (loss_cnt == LOSS_W'(LOSS_LIMIT - 1));

  assign step = line_tick ? line_step :
                (use_xtal && xtal_step) ? 2'd1 : 2'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_acc <= '0;
      xtal_acc <= '0;
      loss_cnt <= '0;
      mains_ok <= 1'b0;
    end else begin
      if (clear_frac)     line_acc <= '0;
      else if (line_tick) line_acc <= line_rem;

      if (clear_frac || mains_ok) xtal_acc <= '0;
      else if (use_xtal)          xtal_acc <= xtal_step ? xtal_sum - XACC_W'(XTAL_HZ) : xtal_sum;

      if (line_tick) begin
        mains_ok <= 1'b1;
        loss_cnt <= '0;
      end else if (xtal_tick && mains_ok) begin
        if (loss_hit) begin
          mains_ok <= 1'b0;
          loss_cnt <= '0;
        end else begin
          loss_cnt <= loss_cnt + LOSS_W'(1);
        end
      end
    end
  end

  // R7
  present_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mains_ok) |-> $past(line_tick));
  // R7
  present_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mains_ok) |-> ($past(xtal_tick) && !$past(line_tick)));
  // R8
  xtal_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mains_ok && xtal_tick && !line_tick) |-> (step == 2'd0));
  // R2
  fifty_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_tick && !sel_60hz) |-> (step == 2'd2));
endmodule

// File: rtl/mct_counter.sv
module mct_counter
  import mct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        step,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cal_wr,
  output logic [6:0]        hund,
  output logic [5:0]        sec,
  output logic [5:0]        min,
  output logic [4:0]        hour,
  output logic [4:0]        day,
  output logic [3:0]        mon,
  output logic [6:0]        year,
  output logic [2:0]        wday,
  output logic              mode12,
  output logic              dst_en,
  output logic [3:0]        ds_sm,
  output logic [4:0]        ds_sd,
  output logic [3:0]        ds_em,
  output logic [4:0]        ds_ed
);
  logic [7:0] h_sum;
  logic       sec_c, min_c, hr_c, day_c, mon_c, yr_c;
  logic       dst_spring, dst_fall, fb_done;
  logic [6:0] n_hund;
  logic [5:0] n_sec, n_min;
  logic [4:0] n_hour, n_day;
  logic [3:0] n_mon;
  logic [6:0] n_year;
  logic [2:0] n_wday;

  assign cal_wr = wr_en && (wr_addr <= 4'(RA_WDAY));

  // Carry chain as named events.
  assign h_sum  = {1'b0, hund} + {6'b0, (cal_wr ? 2'd0 : step)};
  assign sec_c  = (h_sum >= 8'd100);
  assign min_c  = sec_c && (sec == 6'd59);
  assign hr_c   = min_c && (min == 6'd59);
  assign day_c  = hr_c && (hour == 5'd23);
  assign mon_c  = day_c && (day >= month_days(mon, year));
  assign yr_c   = mon_c && (mon >= 4'd12);

  assign dst_spring = dst_en && hr_c && (hour == 5'd1) &&
                      (mon == ds_sm) && (day == ds_sd);
  assign dst_fall   = dst_en && hr_c && (hour == 5'd1) && !dst_spring &&
                      (mon == ds_em) && (day == ds_ed) && !fb_done;

  always_comb begin
    n_hund = sec_c ? 7'(h_sum - 8'd100) : h_sum[6:0];
    n_sec  = sec_c ? ((sec == 6'd59) ? 6'd0 : sec + 6'd1) : sec;
    n_min  = min_c ? ((min == 6'd59) ? 6'd0 : min + 6'd1) : min;
    if (dst_spring)     n_hour = 5'd3;
    else if (dst_fall)  n_hour = 5'd1;
    else if (hr_c)      n_hour = (hour == 5'd23) ? 5'd0 : hour + 5'd1;
    else                n_hour = hour;
    n_day  = mon_c ? 5'd1 : (day_c ? day + 5'd1 : day);
    n_wday = day_c ? ((wday == 3'd6) ? 3'd0 : wday + 3'd1) : wday;
    n_mon  = yr_c ? 4'd1 : (mon_c ? mon + 4'd1 : mon);
    n_year = yr_c ? ((year == 7'd99) ? 7'd0 : year + 7'd1) : year;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hund <= '0; sec <= '0; min <= '0; hour <= '0;
      day <= 5'd1; mon <= 4'd1; year <= '0; wday <= '0;
      mode12 <= 1'b0; dst_en <= 1'b0;
      ds_sm <= '0; ds_sd <= '0; ds_em <= '0; ds_ed <= '0;
      fb_done <= 1'b0;
    end else if (cal_wr) begin
      hund <= (wr_addr == 4'(RA_HUND)) ? wr_data[6:0] : 7'd0;
      case (reg_addr_e'(wr_addr))
        RA_SEC:  sec  <= wr_data[5:0];
        RA_MIN:  min  <= wr_data[5:0];
        RA_HOUR: hour <= wr_data[4:0];
        RA_DAY:  day  <= wr_data[4:0];
        RA_MON:  mon  <= wr_data[3:0];
        RA_YEAR: year <= wr_data[6:0];
        RA_WDAY: wday <= wr_data[2:0];
        default: ;
      endcase
    end else begin
      hund <= n_hund; sec <= n_sec; min <= n_min; hour <= n_hour;
      day <= n_day; mon <= n_mon; year <= n_year; wday <= n_wday;
      if (day_c)         fb_done <= 1'b0;
      else if (dst_fall) fb_done <= 1'b1;
      if (wr_en) begin
        case (reg_addr_e'(wr_addr))
          RA_CTRL:  begin mode12 <= wr_data[0]; dst_en <= wr_data[1]; end
          RA_DS_SM: ds_sm <= wr_data[3:0];
          RA_DS_SD: ds_sd <= wr_data[4:0];
          RA_DS_EM: ds_em <= wr_data[3:0];
          RA_DS_ED: ds_ed <= wr_data[4:0];
          default: ;
        endcase
      end
    end
  end

  // R4
  hund_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cal_wr) && ($past(hund) < 7'd100)) |-> (hund < 7'd100));
  // R4
  sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cal_wr) && ($past(sec) < 6'd60)) |-> (sec < 6'd60));
  // R5
  month_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mon_c |=> (day == 5'd1));
  // R10
  spring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_spring |=> (hour == 5'd3 && min == 6'd0));
  // R11
  fall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fb_done) |-> (hour == 5'd1 && $past(hour) == 5'd1));
  // R12
  wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cal_wr && wr_addr != 4'(RA_HUND)) |-> (hund == 7'd0));
endmodule

// File: rtl/mains_calendar_keeper.sv
module mains_calendar_keeper
  import mct_pkg::*;
#(
  parameter int XTAL_HZ    = 32768,
  parameter int LOSS_LIMIT = 819
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_tick,
  input  logic              xtal_tick,
  input  logic              sel_60hz,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              mains_ok
);
  logic [1:0] step;
  logic       cal_wr, mode12, dst_en;
  logic [6:0] hund, year;
  logic [5:0] sec, min;
  logic [4:0] hour, day, ds_sd, ds_ed;
  logic [3:0] mon, ds_sm, ds_em;
  logic [2:0] wday;

  mct_timebase #(.XTAL_HZ(XTAL_HZ), .LOSS_LIMIT(LOSS_LIMIT)) u_tb (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .xtal_tick(xtal_tick),
    .sel_60hz(sel_60hz), .clear_frac(cal_wr), .step(step), .mains_ok(mains_ok)
  );

  mct_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cal_wr(cal_wr), .hund(hund), .sec(sec), .min(min),
    .hour(hour), .day(day), .mon(mon), .year(year), .wday(wday),
    .mode12(mode12), .dst_en(dst_en), .ds_sm(ds_sm), .ds_sd(ds_sd),
    .ds_em(ds_em), .ds_ed(ds_ed)
  );

  always_comb begin
    case (reg_addr_e'(rd_addr))
      RA_HUND:  rd_data = {1'b0, hund};
      RA_SEC:   rd_data = {2'b0, sec};
      RA_MIN:   rd_data = {2'b0, min};
      RA_HOUR:  rd_data = {2'b0, disp_hour(hour, mode12)};
      RA_DAY:   rd_data = {3'b0, day};
      RA_MON:   rd_data = {4'b0, mon};
      RA_YEAR:  rd_data = {1'b0, year};
      RA_WDAY:  rd_data = {5'b0, wday};
      RA_CTRL:  rd_data = {6'b0, dst_en, mode12};
      RA_DS_SM: rd_data = {4'b0, ds_sm};
      RA_DS_SD: rd_data = {3'b0, ds_sd};
      RA_DS_EM: rd_data = {4'b0, ds_em};
      RA_DS_ED: rd_data = {3'b0, ds_ed};
      default:  rd_data = '0;
    endcase
  end

  // R9
  hour_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 4'(RA_HOUR) && mode12) |-> (rd_data[4:0] >= 5'd1 && rd_data[4:0] <= 5'd12));
endmodule

// File: tb/sim_mains_calendar_keeper.sv
module sim_mains_calendar_keeper;
  localparam int XHZ = 200;
  localparam int LL  = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0, line_tick = 1'b0, xtal_tick = 1'b0, sel_60hz = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0, probe_addr = '0;
  logic [7:0] wr_data = '0;
  logic       probe_en = 1'b0;
  wire  [7:0] rd_data;
  wire        mains_ok;
  int vectors = 0, errors = 0;

  // Behavioural reference state.
  int m_h, m_s, m_mi, m_hr, m_d, m_mo, m_y, m_w;
  int m_c12, m_dst, m_sm, m_sd, m_em, m_ed, m_fb;
  int m_lacc, m_xacc, m_pres, m_loss;

  always #4 clk = ~clk;

  mains_calendar_keeper #(.XTAL_HZ(XHZ), .LOSS_LIMIT(LL)) u0 (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .xtal_tick(xtal_tick),
    .sel_60hz(sel_60hz), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .mains_ok(mains_ok)
  );

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int feb_len(int y);
    return (y % 4 == 0) ? 29 : 28;
  endfunction

  function automatic int len_of(int mo, int y);
    int short_months[$] = '{4, 6, 9, 11};
    if (mo == 2) return feb_len(y);
    foreach (short_months[i]) if (short_months[i] == mo) return 30;
    return 31;
  endfunction

  function automatic int expect_rd(int a);
    int h;
    case (a)
      0: return m_h;   1: return m_s;  2: return m_mi;
      3: begin
        if (m_c12 == 0) return m_hr;
        h = m_hr % 12;
        if (h == 0) h = 12;
        return h + ((m_hr >= 12) ? 32 : 0);
      end
      4: return m_d;   5: return m_mo; 6: return m_y;  7: return m_w;
      8: return m_c12 + 2 * m_dst;
      9: return m_sm;  10: return m_sd; 11: return m_em; 12: return m_ed;
      default: return 0;
    endcase
  endfunction

  task automatic model_second();
    m_s++;
    if (m_s < 60) return;
    m_s = 0; m_mi++;
    if (m_mi < 60) return;
    m_mi = 0;
    if (m_dst == 1 && m_hr == 1 && m_mo == m_sm && m_d == m_sd) begin
      m_hr = 3; return;
    end
    if (m_dst == 1 && m_hr == 1 && m_mo == m_em && m_d == m_ed && m_fb == 0) begin
      m_hr = 1; m_fb = 1; return;
    end
    m_hr++;
    if (m_hr < 24) return;
    m_hr = 0; m_fb = 0; m_w = (m_w + 1) % 7; m_d++;
    if (m_d <= len_of(m_mo, m_y)) return;
    m_d = 1; m_mo++;
    if (m_mo <= 12) return;
    m_mo = 1; m_y = (m_y + 1) % 100;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_h = 0; m_s = 0; m_mi = 0; m_hr = 0; m_d = 1; m_mo = 1; m_y = 0; m_w = 0;
      m_c12 = 0; m_dst = 0; m_sm = 0; m_sd = 0; m_em = 0; m_ed = 0; m_fb = 0;
      m_lacc = 0; m_xacc = 0; m_pres = 0; m_loss = 0;
    end else begin
      int st, p0, a, d;
      bit cw;
      st = 0; p0 = m_pres; a = int'(wr_addr); d = int'(wr_data);
      cw = wr_en && a <= 7;
      if (line_tick) begin
        if (!sel_60hz) st = 2;
        else begin st = (m_lacc + 100) / 60; m_lacc = (m_lacc + 100) % 60; end
      end else if (xtal_tick && p0 == 0) begin
        m_xacc += 100;
        if (m_xacc >= XHZ) begin st = 1; m_xacc -= XHZ; end
      end
      if (p0 == 1) m_xacc = 0;
      if (line_tick) begin m_pres = 1; m_loss = 0; end
      else if (xtal_tick && p0 == 1) begin
        m_loss++;
        if (m_loss == LL) begin m_pres = 0; m_loss = 0; end
      end
      if (cw) begin
        m_lacc = 0; m_xacc = 0;
        m_h = (a == 0) ? d : 0;
        case (a)
          1: m_s = d; 2: m_mi = d; 3: m_hr = d; 4: m_d = d;
          5: m_mo = d; 6: m_y = d; 7: m_w = d; default: ;
        endcase
      end else begin
        if (wr_en) begin
          case (a)
            8: begin m_c12 = d % 2; m_dst = (d / 2) % 2; end
            9: m_sm = d; 10: m_sd = d; 11: m_em = d; 12: m_ed = d;
            default: ;
          endcase
        end
        m_h += st;
        if (m_h >= 100) begin m_h -= 100; model_second(); end
      end
    end
  end

  // Compare against the reference on every clock.
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk($sformatf("R4 reference addr %0d", rd_addr), int'(rd_data), expect_rd(int'(rd_addr)));
      chk("R7 reference mains_ok", int'(mains_ok), m_pres);
    end
  end

  always @(negedge clk) begin
    #1;
    if (probe_en) rd_addr = probe_addr;
    else rd_addr = (rd_addr >= 4'd12) ? 4'd0 : rd_addr + 4'd1;
  end

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr_with_line(int a, int d);
    @(negedge clk); wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d); line_tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; line_tick = 1'b0;
  endtask

  task automatic lt();
    @(negedge clk); line_tick = 1'b1;
    @(negedge clk); line_tick = 1'b0;
  endtask

  task automatic xt();
    @(negedge clk); xtal_tick = 1'b1;
    @(negedge clk); xtal_tick = 1'b0;
  endtask

  task automatic peek(int a, int exp, string tag);
    @(negedge clk); probe_addr = 4'(a); probe_en = 1'b1;
    @(posedge clk); #2;
    chk(tag, int'(rd_data), exp);
    probe_en = 1'b0;
  endtask

  task automatic peek_ok(int exp, string tag);
    @(posedge clk); #2;
    chk(tag, int'(mains_ok), exp);
  endtask

  task automatic near_midnight();
    wr(3, 23); wr(2, 59); wr(1, 59); wr(0, 98);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    peek(0, 0, "R1 hundredths"); peek(3, 0, "R1 hour"); peek(4, 1, "R1 day");
    peek(5, 1, "R1 month"); peek(6, 0, "R1 year"); peek(8, 0, "R1 control");
    peek_ok(0, "R1 mains_ok");
    // R2 50 Hz
    sel_60hz = 1'b0;
    lt(); lt(); lt();
    peek(0, 6, "R2 three 50 Hz ticks");
    peek_ok(1, "R7 mains_ok after line tick");
    // R12 write clears / beats tick
    wr(1, 10);
    peek(0, 0, "R12 hundredths cleared"); peek(1, 10, "R12 seconds loaded");
    wr(0, 40); peek(0, 40, "R12 hundredths loaded");
    wr_with_line(1, 20);
    peek(0, 0, "R12 tick dropped on write"); peek(1, 20, "R12 write wins");
    // R3 60 Hz
    sel_60hz = 1'b1; wr(0, 0);
    lt(); peek(0, 1, "R3 first 60 Hz tick");
    lt(); peek(0, 3, "R3 second 60 Hz tick");
    lt(); peek(0, 5, "R3 third 60 Hz tick");
    sel_60hz = 1'b0;
    // R4 carry chain
    wr(7, 6); wr(4, 15); wr(5, 6); near_midnight(); lt();
    peek(0, 0, "R4 hundredths"); peek(1, 0, "R4 seconds"); peek(2, 0, "R4 minutes");
    peek(3, 0, "R4 hour"); peek(4, 16, "R4 day"); peek(7, 0, "R4 weekday wrap");
    // R5 leap and month lengths
    wr(6, 24); wr(5, 2); wr(4, 28); near_midnight(); lt();
    peek(4, 29, "R5 leap February 29");
    near_midnight(); lt();
    peek(4, 1, "R5 after leap Feb day"); peek(5, 3, "R5 after leap Feb month");
    wr(6, 23); wr(5, 2); wr(4, 28); near_midnight(); lt();
    peek(4, 1, "R5 common Feb day"); peek(5, 3, "R5 common Feb month");
    wr(5, 4); wr(4, 30); near_midnight(); lt();
    peek(5, 5, "R5 30-day month");
    // R6 year rollover
    wr(6, 99); wr(5, 12); wr(4, 31); near_midnight(); lt();
    peek(6, 0, "R6 year"); peek(5, 1, "R6 month"); peek(4, 1, "R6 day");
    // R9 12-hour display
    wr(8, 1);
    wr(3, 0);  peek(3, 12, "R9 midnight 12 AM");
    wr(3, 13); peek(3, 33, "R9 1 PM");
    wr(3, 12); peek(3, 44, "R9 noon 12 PM");
    wr(8, 0);  peek(3, 12, "R9 24-hour form");
    // R10 spring forward
    wr(9, 3); wr(10, 10); wr(11, 11); wr(12, 3); wr(8, 2);
    wr(5, 3); wr(4, 10); wr(3, 1); wr(2, 59); wr(1, 59); wr(0, 98); lt();
    peek(3, 3, "R10 spring hour"); peek(2, 0, "R10 spring minute");
    // R11 fall back once
    wr(5, 11); wr(4, 3); wr(3, 1); wr(2, 59); wr(1, 59); wr(0, 98); lt();
    peek(3, 1, "R11 first fall back"); peek(2, 0, "R11 minute after fall");
    wr(2, 59); wr(1, 59); wr(0, 98); lt();
    peek(3, 2, "R11 no second fall back");
    // R7 / R8 crystal fallback
    wr(0, 0);
    xt(); xt(); xt(); xt();
    peek_ok(1, "R7 still present before limit");
    peek(0, 0, "R8 crystal ignored while mains present");
    xt();
    peek_ok(0, "R7 mains lost at limit");
    xt(); xt(); xt(); xt();
    peek(0, 2, "R7 crystal hundredths");
    lt();
    peek_ok(1, "R7 mains back");
    peek(0, 4, "R7 line resumes without loss");
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule